// File: doc/BRIEF.md
# Hardware Breakpoint Matcher

This block watches the access stream of a core for four programmable breakpoints. Each slot holds a linear address, a type code and a length code, plus a local and a global enable. Every access presented on the input stream is compared against all slots in parallel. The stream carries a byte address, four byte-lane enables for the doubleword that holds that address, an access kind, a single-step flag and a task-switch trap indication. The block then updates a sticky status register and pulses a fault request or a trap request, or both, one cycle later.

The access input is a valid/ready stream. `acc_ready` is held high, so the block never applies back-pressure. Every cycle with `acc_valid` high is an accepted access, and its result shows on `fault_req`, `trap_req` and `status` after the next rising clock edge. The slot configuration and the status write port are plain level inputs. Software clears or rewrites the status through `stat_wr`/`stat_wdata`.

Top module: `brkpt_match`

## Requirements
- R1: While reset is active and in the first cycle after it, `status` is 0 and `fault_req` and `trap_req` are 0. `acc_ready` is 1.
- R2: Type code 00 matches only fetches (acc_kind 00). Type 01 matches only writes (acc_kind 10). Type 11 matches reads (acc_kind 01) and writes, never fetches.
- R3: Length code 00 watches one byte, 01 watches two bytes and 11 watches four bytes. For a length of two, address bit 0 of the slot address is ignored. For a length of four, bits 1:0 are ignored. This aligns the watched field.
- R4: A data access matches when it targets the same doubleword as the watched field and any of its enabled byte lanes (acc_be bit i = byte address offset i) overlaps the field.
- R5: An execution slot matches only a fetch whose byte address equals the slot address exactly. It requires length code 00. A match on an enabled execution slot produces `fault_req`.
- R6: Type code 10 or length code 10 never matches. An execution slot with a nonzero length never matches.
- R7: A match on a slot with both its local and its global enable clear raises no request and leaves `status` unchanged, unless some other condition fires.
- R8: When any request is raised, `status` bit n (n = 0..3) is set for every slot n that matched, whether or not that slot is enabled.
- R9: An accepted access with `step_flag` high raises `trap_req` and sets status bit 5.
- R10: An accepted access with `task_trap` high raises `trap_req` and sets status bit 4. No enable is needed.
- R11: Status bits are sticky. They are only cleared or replaced by `stat_wr`, which loads `stat_wdata`. Bits set by an access in the same cycle are ORed on top.
- R12: Data matches, single-step and task traps produce `trap_req`. Execution matches produce `fault_req`. Both can be raised by the same access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access stream valid |
| acc_ready | output | 1 | Access stream ready, always 1 |
| acc_addr | input | ADDR_W | Byte linear address of the access |
| acc_be | input | 4 | Byte lanes of the addressed doubleword |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write |
| step_flag | input | 1 | Single-step active for this access |
| task_trap | input | 1 | Entered a task whose trap bit is set |
| slot_addr | input | NUM_SLOTS*ADDR_W | Slot linear addresses, slot n at bits n*ADDR_W |
| slot_type | input | 2*NUM_SLOTS | Type code per slot |
| slot_len | input | 2*NUM_SLOTS | Length code per slot |
| slot_local_en | input | NUM_SLOTS | Local enable per slot |
| slot_global_en | input | NUM_SLOTS | Global enable per slot |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | NUM_SLOTS+2 | Status write value |
| status | output | NUM_SLOTS+2 | {single-step, task, slot hits} |
| fault_req | output | 1 | Fault request pulse |
| trap_req | output | 1 | Trap request pulse |

## Verification
The bench builds the block with its default parameters: four slots and a 32-bit address. Under that build each slot can take a different type and length at once. This lets a single access reach an enabled and a disabled slot together, and an execution slot alongside a step trap. Reconfiguring slots between accesses covers the undefined codes and a misused execution length. The status bit positions stay fixed at 0..3, 4 and 5.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;
  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_WRITE = 2'b10;

  localparam logic [1:0] TYP_EXEC  = 2'b00;
  localparam logic [1:0] TYP_WRITE = 2'b01;
  localparam logic [1:0] TYP_RDWR  = 2'b11;

  localparam logic [1:0] LEN_1 = 2'b00;
  localparam logic [1:0] LEN_2 = 2'b01;
  localparam logic [1:0] LEN_4 = 2'b11;

  function automatic logic [1:0] low_mask(input logic [1:0] len);
    case (len)
      LEN_2:   low_mask = 2'b01;
      LEN_4:   low_mask = 2'b11;
      default: low_mask = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/brkpt_slot.sv
module brkpt_slot
  import brkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic [1:0]        slot_type,
  input  logic [1:0]        slot_len,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_be,
  input  logic [1:0]        acc_kind,
  output logic              hit
);
  logic [ADDR_W-1:0] base;
  logic [3:0]        field;
  logic              same_dw, data_hit, len_ok;

  always_comb begin
    base = slot_addr & ~{{(ADDR_W-2){1'b0}}, low_mask(slot_len)};
    case (slot_len)
      LEN_1:   field = 4'b0001 << base[1:0];
      LEN_2:   field = base[1] ? 4'b1100 : 4'b0011;
      LEN_4:   field = 4'b1111;
      default: field = 4'b0000;
    endcase
    len_ok   = (slot_len != 2'b10);
    same_dw  = (base[ADDR_W-1:2] == acc_addr[ADDR_W-1:2]);
    data_hit = len_ok && same_dw && (|(field & acc_be));
    case (slot_type)
      TYP_EXEC:  hit = (acc_kind == KIND_FETCH) && (slot_len == LEN_1) &&
                       (acc_addr == slot_addr);
      TYP_WRITE: hit = (acc_kind == KIND_WRITE) && data_hit;
      TYP_RDWR:  hit = ((acc_kind == KIND_READ) || (acc_kind == KIND_WRITE)) && data_hit;
      default:   hit = 1'b0;
    endcase
  end

  // R6: the undefined type code must never produce a hit
  always_comb begin
    if (slot_type == 2'b10) a_r6_undef_type: assert (!hit);
  end
endmodule

// File: rtl/brkpt_status.sv
module brkpt_status #(
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_bits,
  input  logic          wr,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] status
);
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (wr ? wdata : status) | set_bits;
  end

  // R11: without a write, no bit ever falls
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/brkpt_match.sv
module brkpt_match
  import brkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  localparam int SW       = NUM_SLOTS + 2,
  localparam int BT_BIT   = NUM_SLOTS,
  localparam int BS_BIT   = NUM_SLOTS + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  output logic                          acc_ready,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [3:0]                    acc_be,
  input  logic [1:0]                    acc_kind,
  input  logic                          step_flag,
  input  logic                          task_trap,
  input  logic [NUM_SLOTS*ADDR_W-1:0]   slot_addr,
  input  logic [2*NUM_SLOTS-1:0]        slot_type,
  input  logic [2*NUM_SLOTS-1:0]        slot_len,
  input  logic [NUM_SLOTS-1:0]          slot_local_en,
  input  logic [NUM_SLOTS-1:0]          slot_global_en,
  input  logic                          stat_wr,
  input  logic [SW-1:0]                 stat_wdata,
  output logic [SW-1:0]                 status,
  output logic                          fault_req,
  output logic                          trap_req
);
  logic [NUM_SLOTS-1:0] hits, armed;
  logic                 is_data, raise_fault, raise_trap;
  logic [SW-1:0]        set_bits;

  assign acc_ready = 1'b1;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    brkpt_slot #(.ADDR_W(ADDR_W)) u_slot (
      .slot_addr (slot_addr[n*ADDR_W +: ADDR_W]),
      .slot_type (slot_type[2*n +: 2]),
      .slot_len  (slot_len[2*n +: 2]),
      .acc_addr  (acc_addr),
      .acc_be    (acc_be),
      .acc_kind  (acc_kind),
      .hit       (hits[n])
    );
  end

  always_comb begin
    armed       = hits & (slot_local_en | slot_global_en);
    is_data     = (acc_kind == KIND_READ) || (acc_kind == KIND_WRITE);
    raise_fault = acc_valid && (acc_kind == KIND_FETCH) && (|armed);
    raise_trap  = acc_valid && (step_flag || task_trap || (is_data && (|armed)));
    set_bits    = (raise_fault || raise_trap) ? {step_flag, task_trap, hits} : '0;
  end

  brkpt_status #(.SW(SW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_bits),
    .wr       (stat_wr),
    .wdata    (stat_wdata),
    .status   (status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_req <= 1'b0;
      trap_req  <= 1'b0;
    end else begin
      fault_req <= raise_fault;
      trap_req  <= raise_trap;
    end
  end

  // R12: a fault only follows an accepted fetch
  a_r12_fault_from_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> $past(acc_valid && (acc_kind == KIND_FETCH)));
  // R9: single-step always traps and marks its bit
  a_r9_step_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && step_flag) |=> (trap_req && status[BS_BIT]));
  // R10: task trap needs no enable
  a_r10_task_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && task_trap) |=> (trap_req && status[BT_BIT]));
  // R7: status moves only with a write or a raised request
  a_r7_quiet_status: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status == $past(status)) || fault_req || trap_req));
endmodule

// File: tb/brkpt_match_test.sv
module brkpt_match_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [1:0]  acc_kind = '0;
  logic        step_flag = 1'b0, task_trap = 1'b0;
  logic [31:0] sa [4];
  logic [7:0]  slot_type = '0, slot_len = '0;
  logic [3:0]  slot_local_en = '0, slot_global_en = '0;
  logic        stat_wr = 1'b0;
  logic [5:0]  stat_wdata = '0;
  logic [5:0]  status;
  logic        fault_req, trap_req;
  logic [127:0] slot_addr;

  int tests = 0, fails = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  assign slot_addr = {sa[3], sa[2], sa[1], sa[0]};
  always #5 clk = ~clk;

  brkpt_match uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_kind(acc_kind),
    .step_flag(step_flag), .task_trap(task_trap), .slot_addr(slot_addr),
    .slot_type(slot_type), .slot_len(slot_len), .slot_local_en(slot_local_en),
    .slot_global_en(slot_global_en), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .status(status), .fault_req(fault_req), .trap_req(trap_req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: compare each accepted access one step after the edge
  initial forever begin
    @(posedge clk);
    if (acc_valid && acc_ready) begin
      #1;
      if (q_exp.size() == 0) check("monitor-underflow", 8'h00, 8'hff);
      else check(q_tag.pop_front(), {fault_req, trap_req, status}, q_exp.pop_front());
    end
  end

  task automatic access(input logic [31:0] a, input logic [3:0] be, input logic [1:0] k,
                        input logic st, input logic tt, input logic f, input logic t,
                        input logic [5:0] s, input string tag);
    @(negedge clk);
    acc_addr = a; acc_be = be; acc_kind = k; step_flag = st; task_trap = tt;
    acc_valid = 1'b1;
    q_exp.push_back({f, t, s});
    q_tag.push_back(tag);
    @(negedge clk);
    acc_valid = 1'b0; step_flag = 1'b0; task_trap = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = '0;
    @(negedge clk);
    stat_wr = 1'b0;
    check("R11 clear by write", {2'b00, status}, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 8'h00, 8'h01);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    sa[0] = 32'h1000; sa[1] = 32'h2003; sa[2] = 32'h3004; sa[3] = 32'h5001;
    // slot3: rdwr,len1 | slot2: exec,len1 | slot1: write,len2 | slot0: rdwr,len4
    slot_type = {2'b11, 2'b00, 2'b01, 2'b11};
    slot_len  = {2'b00, 2'b00, 2'b01, 2'b11};
    slot_global_en = 4'b0101; slot_local_en = 4'b0010;
    repeat (3) @(negedge clk);
    check("R1 reset state", {fault_req, trap_req, status}, 8'h00);
    check("R1 ready", {7'd0, acc_ready}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {fault_req, trap_req, status}, 8'h00);

    access(32'h1000, 4'b0001, 2'b01, 0, 0, 0, 1, 6'h01, "R2 read hits rdwr slot");
    clear_status();
    access(32'h1000, 4'b1000, 2'b10, 0, 0, 0, 1, 6'h01, "R4 byte3 inside 4-byte field");
    clear_status();
    access(32'h2000, 4'b0100, 2'b10, 0, 0, 0, 1, 6'h02, "R3 len2 masks slot bit0");
    clear_status();
    access(32'h2000, 4'b0010, 2'b10, 0, 0, 0, 0, 6'h00, "R3 byte below aligned field");
    access(32'h2000, 4'b1100, 2'b01, 0, 0, 0, 0, 6'h00, "R2 read ignores write slot");
    access(32'h2000, 4'b1111, 2'b10, 0, 0, 0, 1, 6'h02, "R4 wide write overlaps");
    clear_status();
    access(32'h3004, 4'b0001, 2'b00, 0, 0, 1, 0, 6'h04, "R5 exec exact match fault");
    clear_status();
    access(32'h3005, 4'b0010, 2'b00, 0, 0, 0, 0, 6'h00, "R5 exec off-by-one");
    access(32'h3004, 4'b0001, 2'b01, 0, 0, 0, 0, 6'h00, "R2 read ignores exec slot");
    access(32'h1000, 4'b0001, 2'b00, 0, 0, 0, 0, 6'h00, "R2 fetch ignores rdwr slot");
    access(32'h5000, 4'b0010, 2'b01, 0, 0, 0, 0, 6'h00, "R7 disabled slot silent");
    access(32'h5000, 4'b0010, 2'b01, 1, 0, 0, 1, 6'h28, "R8 disabled hit recorded with step");
    clear_status();
    access(32'h4000, 4'b0001, 2'b00, 1, 0, 0, 1, 6'h20, "R9 single-step trap");
    clear_status();
    access(32'h3004, 4'b0001, 2'b00, 1, 0, 1, 1, 6'h24, "R12 fault and trap together");
    clear_status();
    access(32'h9000, 4'b0001, 2'b01, 0, 1, 0, 1, 6'h10, "R10 task trap no enable");
    access(32'h1000, 4'b0001, 2'b01, 0, 0, 0, 1, 6'h11, "R11 sticky accumulation");
    @(negedge clk);
    check("R11 holds without write", {2'b00, status}, 8'h11);
    clear_status();

    @(negedge clk);
    slot_type[3:2] = 2'b10;
    access(32'h2000, 4'b1100, 2'b10, 0, 0, 0, 0, 6'h00, "R6 undefined type");
    slot_type[3:2] = 2'b01; slot_len[3:2] = 2'b10;
    access(32'h2000, 4'b1100, 2'b10, 0, 0, 0, 0, 6'h00, "R6 undefined length");
    slot_len[5:4] = 2'b11;
    access(32'h3004, 4'b0001, 2'b00, 0, 0, 0, 0, 6'h00, "R6 exec with nonzero length");

    repeat (3) @(negedge clk);
    check("queue drained", {7'd0, q_exp.size() == 0}, 8'h01);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule